// File: doc/BRIEF.md
# Configurable SPI Master/Slave Shift Engine

This block is one serial shift engine that plays either end of an SPI link. A static configuration picks the role, the frame length, the clock mode, the bit order, the active level of the select line and, in master role, whether select is driven by a software level or wrapped around each frame by the hardware. The clock mode is given as a sparse 3-bit code rather than as raw polarity and phase bits. Codes outside the four defined ones are refused.

A parallel side presents a transmit word and a one-cycle start request. In master role the engine builds SCK from a programmable half-period counter, drives MOSI and select, samples MISO, and ends with a one-cycle `done` pulse that carries the received word, right-justified. In slave role it synchronises an external SCK, select and MOSI, shifts the transmit word out on MISO, and drives MISO only while selected. It raises `done` once per completed frame.

The configuration is expected to stay constant while a frame is in flight.

Top module: `spi_engine`

## Requirements
- R1: After a synchronous reset the engine is a slave, `done`, `busy`, `rx_word`, `m_sck` and `s_miso_oe` are 0, and `m_sel` is 1 (inactive for the reset active-low polarity).
- R2: `cfg_format` selects the clock mode: 3'b001 gives CPOL 0 / CPHA 0, 3'b010 gives CPOL 0 / CPHA 1, 3'b110 gives CPOL 1 / CPHA 0, and 3'b101 gives CPOL 1 / CPHA 1. Any other code makes a start request do nothing: `busy` stays 0, select stays inactive and no `done` appears.
- R3: Whenever no frame is running in master role, `m_sck` rests at CPOL (low for CPOL 0, high for CPOL 1).
- R4: With CPHA 0 each bit is captured on its first SCK edge and launched before that edge. With CPHA 1 each bit is launched on its first edge and captured on its second edge. A frame has exactly 2N SCK edges.
- R5: `cfg_lsb_first` = 0 sends and assembles the most significant frame bit first. A value of 1 sends and assembles bit 0 first. This holds in both roles.
- R6: `cfg_len` = 0 gives a 16-bit frame and 1..15 gives that many bits. The received word is right-justified in `rx_word`, and the upper bits are 0.
- R7: `cfg_sel_high` = 0 makes select active low and 1 makes it active high. This applies to `m_sel` and to `s_sel`.
- R8: With `cfg_sel_auto` = 1, `m_sel` turns active on the clock edge that accepts the start. It turns inactive one half-period after the last SCK edge, on the same edge that raises `done`.
- R9: With `cfg_sel_auto` = 0 in master role, `m_sel` follows `sw_sel` one cycle later. In slave role `sw_sel` has no effect and `m_sel` stays inactive.
- R10: In master role the SCK half-period is `cfg_div`+1 clocks. The first SCK edge comes one half-period after the accepting edge, and `done` comes (2N+1) half-periods after it.
- R11: A start request while a master frame is running is ignored: the frame, its word and its timing are unchanged.
- R12: In slave role `s_miso_oe` is 0 while select is inactive. Deselecting mid-frame discards the partial frame, so the next frame is received whole.
- R13: `done` is a single-cycle pulse, and `rx_word` holds the new frame in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 master role, 0 slave role |
| cfg_sel_auto | input | 1 | 1 hardware-framed select, 0 software select (master only) |
| cfg_lsb_first | input | 1 | 1 bit 0 first, 0 top bit first |
| cfg_sel_high | input | 1 | Select active level |
| cfg_format | input | 3 | Clock-mode code |
| cfg_len | input | 4 | Frame length, 0 means 16 |
| cfg_div | input | 8 | SCK half-period minus one, in clocks |
| sw_sel | input | 1 | Software select request |
| start | input | 1 | Start a master frame |
| tx_word | input | 16 | Word to transmit (right-justified) |
| rx_word | output | 16 | Last received word |
| done | output | 1 | Frame complete pulse |
| busy | output | 1 | Frame running (master) or selected (slave) |
| m_sck | output | 1 | Master serial clock |
| m_sel | output | 1 | Master select |
| m_mosi | output | 1 | Master data out |
| m_miso | input | 1 | Master data in |
| s_sck | input | 1 | Slave serial clock |
| s_sel | input | 1 | Slave select |
| s_mosi | input | 1 | Slave data in |
| s_miso | output | 1 | Slave data out |
| s_miso_oe | output | 1 | Slave data out enable |

## Verification
In master role every result is tied to the clock edge that accepts the start request, counted in half-periods H = `cfg_div`+1. Select is due at once, the first SCK edge after H clocks, and `done` with the deasserted select after (2N+1)·H clocks. The tests count falling clock edges from the accepting edge and compare the exact count for each of these events. Slave inputs pass a two-stage synchroniser plus an edge register, so slave outputs follow an SCK or select change by about three clocks. The emulated remote master therefore holds each SCK level for eight clocks, reads MISO just before its own capture edge, and looks for `done` and the enable level six clocks after the last edge or deselect.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam logic [2:0] FMT_M0 = 3'b001;
  localparam logic [2:0] FMT_M1 = 3'b010;
  localparam logic [2:0] FMT_M2 = 3'b110;
  localparam logic [2:0] FMT_M3 = 3'b101;

  typedef struct packed {
    logic ok;
    logic cpol;
    logic cpha;
  } clk_mode_t;

  typedef enum logic [1:0] {M_IDLE, M_LEAD, M_RUN, M_TRAIL} mst_state_t;
endpackage

// File: rtl/spi_mode_decode.sv
module spi_mode_decode
  import spi_cfg_pkg::*;
(
  input  logic [2:0] fmt,
  output clk_mode_t  mode
);
  always_comb begin
    mode = '0;
    case (fmt)
      FMT_M0: mode = '{ok: 1'b1, cpol: 1'b0, cpha: 1'b0};
      FMT_M1: mode = '{ok: 1'b1, cpol: 1'b0, cpha: 1'b1};
      FMT_M2: mode = '{ok: 1'b1, cpol: 1'b1, cpha: 1'b0};
      FMT_M3: mode = '{ok: 1'b1, cpol: 1'b1, cpha: 1'b1};
      default: mode = '0;
    endcase
  end
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spi_cfg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              fmt_ok,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              sel_auto,
  input  logic              sel_high,
  input  logic              sw_sel,
  input  logic [LEN_W-1:0]  len,
  input  logic [DIV_W-1:0]  div,
  input  logic              start,
  input  logic [DATA_W-1:0] tx,
  input  logic              miso,
  output logic              sck,
  output logic              sel,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx
);
  localparam int NB_W  = LEN_W + 1;
  localparam int CNT_W = LEN_W + 2;

  function automatic logic [LEN_W-1:0] bit_pos(input logic lsb,
                                               input logic [NB_W-1:0] n,
                                               input logic [NB_W-1:0] b);
    return lsb ? b[LEN_W-1:0] : LEN_W'(n - NB_W'(1) - b);
  endfunction

  mst_state_t        state;
  logic [DIV_W-1:0]  hcnt;
  logic [CNT_W-1:0]  ecnt;
  logic [DATA_W-1:0] txr, acc;
  logic [NB_W-1:0]   nbits, bidx;
  logic              tick, lead_e, last_e, launch, finish, sel_on;

  assign nbits  = (len == '0) ? NB_W'(DATA_W) : NB_W'(len);
  assign tick   = (hcnt == div);
  assign bidx   = ecnt[CNT_W-1:1];
  assign lead_e = ~ecnt[0];
  assign last_e = (CNT_W'(ecnt + CNT_W'(1)) == {nbits, 1'b0});
  assign launch = (state == M_IDLE) && start && en && fmt_ok;
  assign finish = (state == M_TRAIL) && tick;
  assign sel_on = en && (sel_auto ? (launch || (state != M_IDLE && !finish)) : sw_sel);
  assign busy   = (state != M_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= M_IDLE;
      hcnt  <= '0;
      ecnt  <= '0;
      txr   <= '0;
      acc   <= '0;
      rx    <= '0;
      sck   <= 1'b0;
      sel   <= 1'b1;
      mosi  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      sel  <= sel_high ? sel_on : ~sel_on;
      case (state)
        M_IDLE: begin
          sck  <= cpol;
          hcnt <= '0;
          if (launch) begin
            state <= M_LEAD;
            txr   <= tx;
            acc   <= '0;
            ecnt  <= '0;
            if (!cpha) mosi <= tx[bit_pos(lsb_first, nbits, '0)];
          end
        end
        M_LEAD, M_RUN: begin
          if (tick) begin
            hcnt  <= '0;
            sck   <= ~sck;
            ecnt  <= ecnt + CNT_W'(1);
            state <= last_e ? M_TRAIL : M_RUN;
            if (lead_e ^ cpha) begin
              acc[bit_pos(lsb_first, nbits, bidx)] <= miso;
            end else if (lead_e) begin
              mosi <= txr[bit_pos(lsb_first, nbits, bidx)];
            end else if (NB_W'(bidx + NB_W'(1)) < nbits) begin
              mosi <= txr[bit_pos(lsb_first, nbits, NB_W'(bidx + NB_W'(1)))];
            end
          end else begin
            hcnt <= hcnt + DIV_W'(1);
          end
        end
        M_TRAIL: begin
          if (tick) begin
            state <= M_IDLE;
            done  <= 1'b1;
            rx    <= acc;
            hcnt  <= '0;
          end else begin
            hcnt <= hcnt + DIV_W'(1);
          end
        end
        default: state <= M_IDLE;
      endcase
    end
  end

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sck == cpol));
  // R8
  auto_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sel_auto && $stable(en) && $stable(sel_auto) && $stable(sel_high))
      |-> ((sel == sel_high) == busy));
  // R4
  edge_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (ecnt <= {nbits, 1'b0}));
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/spi_slave_core.sv
module spi_slave_core #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              sel_high,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] tx,
  input  logic              sck_in,
  input  logic              sel_in,
  input  logic              mosi_in,
  output logic              miso,
  output logic              miso_oe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx
);
  localparam int NB_W = LEN_W + 1;

  function automatic logic [LEN_W-1:0] bit_pos(input logic lsb,
                                               input logic [NB_W-1:0] n,
                                               input logic [NB_W-1:0] b);
    return lsb ? b[LEN_W-1:0] : LEN_W'(n - NB_W'(1) - b);
  endfunction

  logic [1:0]        sck_q, sel_q, dat_q;
  logic              sck_d, armed;
  logic [NB_W-1:0]   nbits, k;
  logic [DATA_W-1:0] txr, acc, acc_n;
  logic              sel_act, rise, fall, lead, trail, samp, drv;

  assign nbits   = (len == '0) ? NB_W'(DATA_W) : NB_W'(len);
  assign sel_act = en && (sel_q[1] == sel_high);
  assign rise    = sck_q[1] & ~sck_d;
  assign fall    = ~sck_q[1] & sck_d;
  assign lead    = cpol ? fall : rise;
  assign trail   = cpol ? rise : fall;
  assign samp    = cpha ? trail : lead;
  assign drv     = cpha ? lead : trail;
  assign busy    = armed;

  always_comb begin
    acc_n = acc;
    acc_n[bit_pos(lsb_first, nbits, k)] = dat_q[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q   <= '0;
      sel_q   <= '0;
      dat_q   <= '0;
      sck_d   <= 1'b0;
      armed   <= 1'b0;
      k       <= '0;
      txr     <= '0;
      acc     <= '0;
      rx      <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
      done    <= 1'b0;
    end else begin
      sck_q   <= {sck_q[0], sck_in};
      sel_q   <= {sel_q[0], sel_in};
      dat_q   <= {dat_q[0], mosi_in};
      sck_d   <= sck_q[1];
      done    <= 1'b0;
      miso_oe <= sel_act;
      if (!sel_act) begin
        armed <= 1'b0;
        k     <= '0;
        acc   <= '0;
      end else if (!armed) begin
        armed <= 1'b1;
        txr   <= tx;
        if (!cpha) miso <= tx[bit_pos(lsb_first, nbits, '0)];
      end else begin
        if (samp) begin
          if (k == NB_W'(nbits - NB_W'(1))) begin
            done <= 1'b1;
            rx   <= acc_n;
            acc  <= '0;
            k    <= '0;
          end else begin
            acc <= acc_n;
            k   <= k + NB_W'(1);
          end
        end
        if (drv && (cpha || k != '0)) miso <= txr[bit_pos(lsb_first, nbits, k)];
      end
    end
  end

  // R12
  unsel_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_act |=> !miso_oe);
  // R13
  sdone_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_cfg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_master,
  input  logic              cfg_sel_auto,
  input  logic              cfg_lsb_first,
  input  logic              cfg_sel_high,
  input  logic [2:0]        cfg_format,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              sw_sel,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  output logic [DATA_W-1:0] rx_word,
  output logic              done,
  output logic              busy,
  output logic              m_sck,
  output logic              m_sel,
  output logic              m_mosi,
  input  logic              m_miso,
  input  logic              s_sck,
  input  logic              s_sel,
  input  logic              s_mosi,
  output logic              s_miso,
  output logic              s_miso_oe
);
  clk_mode_t         mode;
  logic              m_busy, m_done, s_busy, s_done;
  logic [DATA_W-1:0] m_rx, s_rx;

  spi_mode_decode u_dec (.fmt(cfg_format), .mode(mode));

  spi_master_core #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_mst (
    .clk(clk), .rst(rst), .en(cfg_master), .fmt_ok(mode.ok),
    .cpol(mode.cpol), .cpha(mode.cpha), .lsb_first(cfg_lsb_first),
    .sel_auto(cfg_sel_auto), .sel_high(cfg_sel_high), .sw_sel(sw_sel),
    .len(cfg_len), .div(cfg_div), .start(start), .tx(tx_word), .miso(m_miso),
    .sck(m_sck), .sel(m_sel), .mosi(m_mosi), .busy(m_busy), .done(m_done), .rx(m_rx)
  );

  spi_slave_core #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_slv (
    .clk(clk), .rst(rst), .en(!cfg_master && mode.ok),
    .cpol(mode.cpol), .cpha(mode.cpha), .lsb_first(cfg_lsb_first),
    .sel_high(cfg_sel_high), .len(cfg_len), .tx(tx_word),
    .sck_in(s_sck), .sel_in(s_sel), .mosi_in(s_mosi),
    .miso(s_miso), .miso_oe(s_miso_oe), .busy(s_busy), .done(s_done), .rx(s_rx)
  );

  assign rx_word = cfg_master ? m_rx : s_rx;
  assign done    = cfg_master ? m_done : s_done;
  assign busy    = cfg_master ? m_busy : s_busy;
endmodule

// File: tb/sim_spi_engine.sv
module sim_spi_engine;
  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_master = 0, cfg_sel_auto = 1, cfg_lsb_first = 0, cfg_sel_high = 0;
  logic [2:0]  cfg_format = 3'b000;
  logic [3:0]  cfg_len = 4'd8;
  logic [7:0]  cfg_div = 8'd1;
  logic        sw_sel = 0, start = 0;
  logic [15:0] tx_word = '0, rx_word;
  logic        done, busy, m_sck, m_sel, m_mosi, m_miso;
  logic        s_sck = 0, s_sel = 1, s_mosi = 0, s_miso, s_miso_oe;

  int checks = 0, fails = 0, done_cnt = 0;
  logic [15:0] last_rx = '0;
  bit summary_done = 0;

  always #10 clk = ~clk;
  assign m_miso = m_mosi;

  spi_engine u0 (.*);

  always @(negedge clk) if (done) begin done_cnt++; last_rx = rx_word; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] mode_of(input logic [2:0] f);
    case (f)
      3'b001: return 2'b00;
      3'b010: return 2'b01;
      3'b110: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic int pos(input bit lsb, input int n, input int b);
    return lsb ? b : n - 1 - b;
  endfunction

  task automatic t_reset();
    wait_clk(1);
    chk(done == 0 && busy == 0, "R1 done/busy", {done, busy}, 0);
    chk(m_sel == 1 && m_sck == 0, "R1 m_sel/m_sck", {m_sel, m_sck}, 2);
    chk(s_miso_oe == 0 && rx_word == 0, "R1 oe/rx", {s_miso_oe, rx_word}, 0);
  endtask

  // R2 R3 R4 R5 R6 R7 R8 R10 R13: one master frame, loopback MOSI->MISO
  task automatic t_master(input logic [2:0] f, input logic [3:0] l, input bit lsb,
                          input logic [7:0] d, input logic [15:0] w, input bit selh,
                          input bit second_start);
    int n = (l == 0) ? 16 : l;
    int h = d + 1;
    logic [15:0] mask = (n == 16) ? 16'hFFFF : 16'((1 << n) - 1);
    logic [1:0] md = mode_of(f);
    logic idle = md[1], cpha = md[0];
    logic [15:0] seen = '0;
    int c = 0, first_e = -1, done_c = -1, sel_off = -1, edges = 0, bitno = 0;
    logic prev;
    cfg_master = 1; cfg_sel_auto = 1; cfg_format = f; cfg_len = l; cfg_lsb_first = lsb;
    cfg_div = d; cfg_sel_high = selh;
    wait_clk(3);
    tx_word = w; start = 1;
    wait_clk(1); start = 0; c = 1; prev = m_sck;
    chk(m_sel == selh, "R8 sel at accept", m_sel, selh);
    chk(m_sck == idle, "R3 idle level", m_sck, idle);
    while (done_c < 0 && c < 3000) begin
      if (second_start && c == 3) begin tx_word = ~w; start = 1; end
      if (second_start && c == 4) start = 0;
      if (m_sck != prev) begin
        edges++;
        if (first_e < 0) first_e = c;
        if ((m_sck != idle) ^ cpha) begin
          if (bitno < 16) seen[pos(lsb, n, bitno)] = m_mosi;
          bitno++;
        end
        prev = m_sck;
      end
      if (sel_off < 0 && m_sel != selh) sel_off = c;
      if (done) done_c = c;
      if (done_c < 0) begin wait_clk(1); c++; end
    end
    chk(first_e == h + 1, "R10 first edge", first_e, h + 1);
    chk(done_c == (2 * n + 1) * h + 1, "R10 done time", done_c, (2 * n + 1) * h + 1);
    chk(sel_off == done_c, "R8 sel release", sel_off, done_c);
    chk(edges == 2 * n && m_sck == idle, "R4 edge count", edges, 2 * n);
    chk(seen == (w & mask), "R5 bit order on MOSI", seen, w & mask);
    chk(rx_word == (w & mask), second_start ? "R11 word kept" : "R6 rx word",
        rx_word, w & mask);
    wait_clk(1);
    chk(done == 0, "R13 done pulse width", done, 0);
  endtask

  task automatic t_reserved(input logic [2:0] f);
    int d0 = done_cnt;
    cfg_master = 1; cfg_sel_auto = 1; cfg_sel_high = 0; cfg_format = f;
    wait_clk(2);
    start = 1; wait_clk(1); start = 0;
    wait_clk(12);
    chk(busy == 0 && m_sel == 1 && done_cnt == d0, "R2 reserved code",
        {busy, m_sel, done_cnt - d0}, 2);
  endtask

  task automatic t_swsel();
    cfg_master = 1; cfg_sel_auto = 0; cfg_sel_high = 1; cfg_format = 3'b001;
    sw_sel = 1; wait_clk(2);
    chk(m_sel == 1, "R9 sw assert", m_sel, 1);
    sw_sel = 0; wait_clk(2);
    chk(m_sel == 0, "R9 sw release", m_sel, 0);
    cfg_master = 0; sw_sel = 1; wait_clk(3);
    chk(m_sel == 0, "R9 ignored in slave role", m_sel, 0);
    sw_sel = 0; cfg_sel_auto = 1;
  endtask

  task automatic s_bits(input int nb, input int n, input bit lsb, input bit idle,
                        input bit cpha, input logic [15:0] mw, inout logic [15:0] got);
    for (int b = 0; b < nb; b++) begin
      if (!cpha) begin
        got[pos(lsb, n, b)] = s_miso;
        s_sck = ~idle; wait_clk(8);
        s_sck = idle;
        if (b + 1 < n) s_mosi = mw[pos(lsb, n, b + 1)];
        wait_clk(8);
      end else begin
        s_sck = ~idle; s_mosi = mw[pos(lsb, n, b)]; wait_clk(8);
        got[pos(lsb, n, b)] = s_miso;
        s_sck = idle; wait_clk(8);
      end
    end
  endtask

  // R2 R4 R5 R6 R7 R12: remote master emulated by the bench
  task automatic t_slave(input logic [2:0] f, input logic [3:0] l, input bit lsb,
                         input bit selh, input logic [15:0] mw, input logic [15:0] sw,
                         input int partial);
    int n = (l == 0) ? 16 : l;
    logic [15:0] mask = (n == 16) ? 16'hFFFF : 16'((1 << n) - 1);
    logic [1:0] md = mode_of(f);
    logic [15:0] got = '0;
    int d0;
    cfg_master = 0; cfg_format = f; cfg_len = l; cfg_lsb_first = lsb; cfg_sel_high = selh;
    tx_word = sw; s_sck = md[1]; s_sel = ~selh;
    wait_clk(6);
    chk(s_miso_oe == 0, "R12 oe low unselected", s_miso_oe, 0);
    d0 = done_cnt;
    if (partial > 0) begin
      if (!md[0]) s_mosi = ~mw[pos(lsb, n, 0)];
      s_sel = selh; wait_clk(8);
      s_bits(partial, n, lsb, md[1], md[0], ~mw, got);
      s_sel = ~selh; wait_clk(6);
      chk(s_miso_oe == 0 && done_cnt == d0, "R12 partial frame dropped",
          {s_miso_oe, done_cnt - d0}, 0);
      got = '0;
    end
    if (!md[0]) s_mosi = mw[pos(lsb, n, 0)];
    s_sel = selh; wait_clk(8);
    chk(s_miso_oe == 1, "R7 slave selected", s_miso_oe, 1);
    s_bits(n, n, lsb, md[1], md[0], mw, got);
    wait_clk(6);
    chk(done_cnt == d0 + 1, "R13 one done per frame", done_cnt - d0, 1);
    chk(last_rx == (mw & mask), "R6 slave rx", last_rx, mw & mask);
    chk(got == (sw & mask), "R5 slave MISO order", got, sw & mask);
    s_sel = ~selh; wait_clk(6);
    chk(s_miso_oe == 0, "R12 oe after deselect", s_miso_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    wait_clk(5);
    rst = 0;
    t_reset();
    t_master(3'b001, 4'd8,  0, 8'd1, 16'h00A5, 0, 0);
    t_master(3'b010, 4'd0,  1, 8'd0, 16'hC3E1, 0, 0);
    t_master(3'b110, 4'd5,  0, 8'd2, 16'h0013, 1, 0);
    t_master(3'b101, 4'd12, 1, 8'd3, 16'h0ABC, 0, 0);
    t_master(3'b001, 4'd8,  0, 8'd1, 16'h005A, 0, 1);
    t_reserved(3'b000);
    t_reserved(3'b111);
    t_swsel();
    t_slave(3'b001, 4'd8, 0, 0, 16'h00A5, 16'h003C, 0);
    t_slave(3'b101, 4'd0, 1, 1, 16'h1234, 16'hBEEF, 0);
    t_slave(3'b010, 4'd7, 0, 0, 16'h0055, 16'h002A, 0);
    t_slave(3'b110, 4'd4, 1, 1, 16'h0009, 16'h0006, 0);
    t_slave(3'b001, 4'd8, 0, 0, 16'h00C6, 16'h0071, 3);
    summary();
  end
endmodule